// File: doc/BRIEF.md
# Modified Miller pause encoder

This block turns reader-to-card frame bits into a single pause control line for a 13.56 MHz carrier. A high level on the line means the carrier is switched off. The block runs on the carrier clock, so one clock cycle is one carrier cycle. A bit period lasts 128 cycles. Each period carries one of three symbols. X has a pause in the second half of the period. Z has a pause at the start of the period. Y has no pause at all. Every pause is 28 cycles long, which is just over 2 us.

A source presents data bits one at a time on a ready/valid port, in transmission order. The first beat of a frame carries the frame type on `in_short`.

- A short frame always holds seven data bits, and `in_last` is ignored for it.
- A standard frame ends at the bit marked `in_last`. After every eighth bit the block adds an odd parity bit. If the frame stops inside a byte, no parity is added, which is the behaviour needed for the reader half of a split anticollision frame.

The block adds the start and end symbols itself. It then holds off the next frame for one bit period, so that frames are always separated by at least two empty periods.

Top module: `miller_pause_encoder`

## Requirements
- R1: After reset, `pause_o` and `busy_o` are low and `in_ready` is high.
- R2: Each symbol period is 128 clock cycles, and every pause is exactly 28 cycles long. A Z pause covers cycles 0..27 of its period. An X pause covers cycles 64..91. A Y period has no pause. Between two pauses the line stays low for at least 36 cycles.
- R3: A data bit of 1 is coded as X. A data bit of 0 is coded as Z when the logic value sent just before it was 0, and as Y otherwise.
- R4: A frame opens with a Z period, which is the start symbol. The start symbol counts as a preceding 0 for R3, so a 0 in the first bit position is sent as Z.
- R5: After the last data or parity bit, the block sends a logic 0 coded by R3 and then one Y period. `busy_o` is high from the first cycle of the start symbol to the last cycle of that Y period, and low otherwise.
- R6: When `in_short`=1 on the first beat, the frame carries exactly 7 data bits with no parity, and `in_last` has no effect.
- R7: In a standard frame (`in_short`=0), each group of 8 data bits is followed by a parity bit chosen so that the 9 bits hold an odd number of ones.
- R8: A standard frame whose last bit completes a byte still sends that byte's parity bit. A standard frame that ends partway through a byte sends no parity for the partial byte.
- R9: The first bit is taken while the block is idle, where `in_ready` is high. Every later bit is taken during a one-cycle `in_ready` pulse in the final cycle of the period before the one that carries it. This pulse appears 126 output cycles into the preceding output period.
- R10: If `in_valid` is low during a ready pulse, the frame closes as if the previous bit had been marked last.
- R11: After `busy_o` falls, `in_ready` stays low until 128 cycles after the last busy cycle, so that at least two empty periods separate frames.
- R12: `pause_o` is never high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier clock, one cycle per carrier period |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A frame bit is offered |
| in_ready | output | 1 | The block takes the offered bit at this edge |
| in_bit | input | 1 | Data bit value |
| in_last | input | 1 | Marks the final bit of a standard frame |
| in_short | input | 1 | Frame type, sampled on the first beat: 1 for a short frame |
| pause_o | output | 1 | Carrier pause request, high while the carrier is off |
| busy_o | output | 1 | High while a frame is on the line |

## Verification
Both outputs are registered after the symbol state. As a result, `busy_o` and the start-symbol pause first appear two edges after the first bit is accepted, and they rise in the same cycle.

The bench takes that first busy cycle as offset zero. It then compares `pause_o` on every cycle of every period with the waveform rebuilt from the requirements. For R9, a ready pulse is allowed only at offset 126 of an output period, and the bench counts the pulses. For R11, `in_ready` is sampled on each of the 128 cycles after the last busy cycle. All samples are taken on the falling clock edge, while inputs are changed only on that edge.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic [1:0] {
    SYM_Y = 2'd0,
    SYM_X = 2'd1,
    SYM_Z = 2'd2
  } mm_sym_t;

  typedef enum logic [1:0] {
    CLS_SOF   = 2'd0,
    CLS_LOGIC = 2'd1,
    CLS_SPACE = 2'd2
  } mm_cls_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SOF    = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_EOF    = 3'd4,
    ST_TRAIL  = 3'd5,
    ST_GUARD  = 3'd6
  } mm_state_t;

endpackage

// File: rtl/mm_bit_timer.sv
module mm_bit_timer #(
  parameter int BIT_CYCLES = 128,
  parameter int CNT_W      = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt,
  output logic             period_end
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_CYCLES - 1);

  assign period_end = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (period_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/mm_symbol_coder.sv
module mm_symbol_coder
  import mm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    step,
  input  mm_cls_t cls,
  input  logic    val,
  output mm_sym_t sym
);

  // Set when the logic value sent just before was 0; the start symbol also sets it.
  logic zero_before_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sym           <= SYM_Y;
      zero_before_q <= 1'b0;
    end else if (step) begin
      case (cls)
        CLS_SOF: begin
          sym           <= SYM_Z;
          zero_before_q <= 1'b1;
        end
        CLS_LOGIC: begin
          if (val) begin
            sym <= SYM_X;
          end else if (zero_before_q) begin
            sym <= SYM_Z;
          end else begin
            sym <= SYM_Y;
          end
          zero_before_q <= ~val;
        end
        default: begin
          sym           <= SYM_Y;
          zero_before_q <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/mm_pause_shaper.sv
module mm_pause_shaper
  import mm_pkg::*;
#(
  parameter int BIT_CYCLES   = 128,
  parameter int PAUSE_CYCLES = 28,
  parameter int CNT_W        = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  mm_sym_t          sym,
  input  logic [CNT_W-1:0] cnt,
  output logic             pause_o,
  output logic             busy_o
);

  localparam logic [CNT_W-1:0] HALF_AT = CNT_W'(BIT_CYCLES / 2);
  localparam logic [CNT_W-1:0] Z_END   = CNT_W'(PAUSE_CYCLES);
  localparam logic [CNT_W-1:0] X_END   = CNT_W'(BIT_CYCLES / 2 + PAUSE_CYCLES);

  logic pause_d;

  always_comb begin
    pause_d = 1'b0;
    if (active) begin
      case (sym)
        SYM_Z:   pause_d = (cnt < Z_END);
        SYM_X:   pause_d = (cnt >= HALF_AT) && (cnt < X_END);
        default: pause_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pause_o <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      pause_o <= pause_d;
      busy_o  <= active;
    end
  end

endmodule

// File: rtl/miller_pause_encoder.sv
module miller_pause_encoder
  import mm_pkg::*;
#(
  parameter int BIT_CYCLES    = 128,
  parameter int PAUSE_CYCLES  = 28,
  parameter int SHORT_BITS    = 7,
  parameter int BYTE_BITS     = 8,
  parameter int GUARD_PERIODS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic in_last,
  input  logic in_short,
  output logic pause_o,
  output logic busy_o
);

  localparam int CNT_W = $clog2(BIT_CYCLES);
  localparam int MAXB  = (SHORT_BITS > BYTE_BITS) ? SHORT_BITS : BYTE_BITS;
  localparam int NB_W  = $clog2(MAXB + 1);
  localparam int GD_W  = (GUARD_PERIODS > 1) ? $clog2(GUARD_PERIODS) : 1;
  localparam logic [NB_W-1:0] NB_SHORT   = NB_W'(SHORT_BITS);
  localparam logic [NB_W-1:0] NB_BYTE    = NB_W'(BYTE_BITS);
  localparam logic [GD_W-1:0] GUARD_LAST = GD_W'(GUARD_PERIODS - 1);

  mm_state_t        state_q, state_d;
  logic [CNT_W-1:0] cnt;
  logic             period_end;
  logic             first_bit_q;
  logic [NB_W-1:0]  nbits_q;
  logic             byte_par_q;
  logic             last_q;
  logic             short_q;
  logic [GD_W-1:0]  gcnt_q;

  logic             step;
  mm_cls_t          cls;
  logic             val;
  mm_sym_t          sym;
  logic             active;

  logic more_bits, byte_full, want_bit, take;

  assign more_bits = short_q ? (nbits_q < NB_SHORT) : ~last_q;
  assign byte_full = ~short_q && (nbits_q == NB_BYTE);
  assign want_bit  = period_end && more_bits &&
                     (((state_q == ST_DATA) && ~byte_full) || (state_q == ST_PARITY));
  assign in_ready  = (state_q == ST_IDLE) || want_bit;
  assign take      = in_ready && in_valid;
  assign active    = (state_q != ST_IDLE) && (state_q != ST_GUARD);

  // Next-period decision: state, symbol class and logic value for the coder.
  always_comb begin
    state_d = state_q;
    step    = 1'b0;
    cls     = CLS_SPACE;
    val     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          state_d = ST_SOF;
          step    = 1'b1;
          cls     = CLS_SOF;
        end
      end
      ST_SOF: begin
        if (period_end) begin
          state_d = ST_DATA;
          step    = 1'b1;
          cls     = CLS_LOGIC;
          val     = first_bit_q;
        end
      end
      ST_DATA: begin
        if (period_end) begin
          step = 1'b1;
          cls  = CLS_LOGIC;
          if (byte_full) begin
            state_d = ST_PARITY;
            val     = ~byte_par_q;
          end else if (take) begin
            state_d = ST_DATA;
            val     = in_bit;
          end else begin
            state_d = ST_EOF;
          end
        end
      end
      ST_PARITY: begin
        if (period_end) begin
          step = 1'b1;
          cls  = CLS_LOGIC;
          if (take) begin
            state_d = ST_DATA;
            val     = in_bit;
          end else begin
            state_d = ST_EOF;
          end
        end
      end
      ST_EOF: begin
        if (period_end) begin
          state_d = ST_TRAIL;
          step    = 1'b1;
          cls     = CLS_SPACE;
        end
      end
      ST_TRAIL: begin
        if (period_end) begin
          state_d = ST_GUARD;
        end
      end
      ST_GUARD: begin
        if (period_end && (gcnt_q == GUARD_LAST)) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      first_bit_q <= 1'b0;
      nbits_q     <= '0;
      byte_par_q  <= 1'b0;
      last_q      <= 1'b0;
      short_q     <= 1'b0;
      gcnt_q      <= '0;
    end else begin
      state_q <= state_d;
      if ((state_q == ST_IDLE) && in_valid) begin
        first_bit_q <= in_bit;
        nbits_q     <= NB_W'(1);
        byte_par_q  <= in_bit;
        last_q      <= in_last;
        short_q     <= in_short;
        gcnt_q      <= '0;
      end else if (period_end && (state_q == ST_DATA) && byte_full) begin
        nbits_q    <= '0;
        byte_par_q <= 1'b0;
      end else if (take) begin
        nbits_q    <= nbits_q + NB_W'(1);
        byte_par_q <= byte_par_q ^ in_bit;
        last_q     <= in_last;
      end
      if ((state_q == ST_GUARD) && period_end) begin
        gcnt_q <= gcnt_q + GD_W'(1);
      end
    end
  end

  mm_bit_timer #(
    .BIT_CYCLES(BIT_CYCLES),
    .CNT_W     (CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart   (state_q == ST_IDLE),
    .cnt       (cnt),
    .period_end(period_end)
  );

  mm_symbol_coder u_coder (
    .clk (clk),
    .rst (rst),
    .step(step),
    .cls (cls),
    .val (val),
    .sym (sym)
  );

  mm_pause_shaper #(
    .BIT_CYCLES  (BIT_CYCLES),
    .PAUSE_CYCLES(PAUSE_CYCLES),
    .CNT_W       (CNT_W)
  ) u_shaper (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .sym    (sym),
    .cnt    (cnt),
    .pause_o(pause_o),
    .busy_o (busy_o)
  );

endmodule

// File: rtl/miller_pause_encoder_checker.sv
module miller_pause_encoder_checker #(
  parameter int BIT_CYCLES   = 128,
  parameter int PAUSE_CYCLES = 28
) (
  input logic clk,
  input logic rst,
  input logic in_ready,
  input logic pause_o,
  input logic busy_o
);

  localparam int RW = $clog2(2 * BIT_CYCLES + 1);
  localparam logic [RW-1:0] RMAX    = {RW{1'b1}};
  localparam logic [RW-1:0] PLEN    = RW'(PAUSE_CYCLES);
  localparam logic [RW-1:0] MIN_GAP = RW'(BIT_CYCLES / 2 - PAUSE_CYCLES);

  logic [RW-1:0] run_q, gap_q;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      run_q <= pause_o ? ((run_q == RMAX) ? run_q : run_q + RW'(1)) : '0;
      gap_q <= pause_o ? '0 : ((gap_q == RMAX) ? gap_q : gap_q + RW'(1));
      if (pause_o) seen_q <= 1'b1;
    end
  end

  a_r12_pause_within_busy: assert property (@(posedge clk) disable iff (rst)
    pause_o |-> busy_o);

  a_r4_sof_opens_with_pause: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> pause_o);

  a_r5_trailing_space_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> !$past(pause_o));

  a_r2_pause_width: assert property (@(posedge clk) disable iff (rst)
    $fell(pause_o) |-> (run_q == PLEN));

  a_r2_pause_not_long: assert property (@(posedge clk) disable iff (rst)
    pause_o |-> (run_q < PLEN));

  a_r2_pause_gap: assert property (@(posedge clk) disable iff (rst)
    ($rose(pause_o) && seen_q) |-> (gap_q >= MIN_GAP));

  a_r9_ready_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (in_ready && busy_o) |=> !in_ready);

  a_r11_guard_holds_ready: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> !in_ready);

endmodule

bind miller_pause_encoder miller_pause_encoder_checker #(
  .BIT_CYCLES  (BIT_CYCLES),
  .PAUSE_CYCLES(PAUSE_CYCLES)
) u_checker (
  .clk     (clk),
  .rst     (rst),
  .in_ready(in_ready),
  .pause_o (pause_o),
  .busy_o  (busy_o)
);

// File: tb/miller_pause_encoder_bench.sv
module miller_pause_encoder_bench;

  localparam int BITC  = 128;
  localparam int PLEN  = 28;
  localparam int HALFC = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_bit = 1'b0, in_last = 1'b0, in_short = 1'b0;
  logic in_ready, pause_o, busy_o;

  int nchk  = 0;
  int nfail = 0;
  int fidx  = 0;

  int    esym [0:127];
  string etag [0:127];
  int    nsym;

  always #2 clk = ~clk;

  miller_pause_encoder u_miller_pause_encoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_last(in_last), .in_short(in_short),
    .pause_o(pause_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s frame %0d %s: actual %0d expected %0d", tag, fidx, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  // symbol codes: 0 = Y, 1 = X, 2 = Z
  function automatic int code_of(input bit b, input bit zb);
    return b ? 1 : (zb ? 2 : 0);
  endfunction

  function automatic bit exp_pause(input int s, input int o);
    if (s == 2) return (o < PLEN);
    if (s == 1) return (o >= HALFC) && (o < HALFC + PLEN);
    return 1'b0;
  endfunction

  task automatic add_sym(input int s, input string t);
    esym[nsym] = s;
    etag[nsym] = t;
    nsym++;
  endtask

  task automatic build(input bit sh, input int neff, input logic [63:0] bits, input bit ur);
    bit zb, par, p;
    nsym = 0;
    add_sym(2, "R4");
    zb  = 1'b1;
    par = 1'b0;
    for (int i = 0; i < neff; i++) begin
      add_sym(code_of(bits[i], zb), (i == 0) ? "R4" : (sh ? "R6" : "R3"));
      zb  = ~bits[i];
      par = par ^ bits[i];
      if (!sh && (i % 8 == 7)) begin
        p = ~par;
        add_sym(code_of(p, zb), (i == neff - 1) ? "R8" : "R7");
        zb  = ~p;
        par = 1'b0;
      end
    end
    if (ur) add_sym(code_of(1'b0, zb), "R10");
    else if (!sh && (neff % 8 != 0)) add_sym(code_of(1'b0, zb), "R8");
    else add_sym(code_of(1'b0, zb), "R5");
    add_sym(0, "R5");
  endtask

  task automatic drive(input bit sh, input int nsend, input int last_at, input logic [63:0] bits);
    @(negedge clk);
    for (int i = 0; i < nsend; i++) begin
      in_valid = 1'b1;
      in_bit   = bits[i];
      in_last  = (i == last_at);
      in_short = sh;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic monitor(input int exp_pulses);
    int wait_n, bad_o, bad_v, rd_bad, pulses, busy_bad, guard_bad;
    wait_n = 0;
    @(negedge clk);
    while (!busy_o && wait_n < 2000) begin
      @(negedge clk);
      wait_n++;
    end
    chk(busy_o, "R5", "busy never rose", 0, 1);
    pulses = 0; rd_bad = 0; busy_bad = 0;
    for (int p = 0; p < nsym; p++) begin
      bad_o = -1; bad_v = 0;
      for (int o = 0; o < BITC; o++) begin
        if (!(p == 0 && o == 0)) @(negedge clk);
        if (pause_o !== exp_pause(esym[p], o) && bad_o < 0) begin
          bad_o = o; bad_v = pause_o;
        end
        if (busy_o !== 1'b1) busy_bad++;
        if (in_ready) begin
          pulses++;
          if (o != 126) rd_bad++;
        end
      end
      chk(bad_o < 0, etag[p], $sformatf("period %0d symbol %0d pause at offset %0d", p, esym[p], bad_o),
          bad_v, exp_pause(esym[p], (bad_o < 0) ? 0 : bad_o));
    end
    chk(busy_bad == 0, "R2", "cycles with busy low inside frame", busy_bad, 0);
    chk(rd_bad == 0, "R9", "ready pulses off offset 126", rd_bad, 0);
    chk(pulses == exp_pulses, "R9", "ready pulse count", pulses, exp_pulses);
    guard_bad = 0;
    for (int g = 1; g <= BITC; g++) begin
      @(negedge clk);
      if (g < BITC && (in_ready || busy_o || pause_o)) guard_bad++;
      if (g == BITC && !in_ready) guard_bad++;
    end
    chk(guard_bad == 0, "R11", "guard period violations", guard_bad, 0);
  endtask

  task automatic run_frame(input bit sh, input int nsend, input int last_at, input logic [63:0] bits);
    int  neff;
    bit  ur;
    if (sh) begin
      neff = (nsend < 7) ? nsend : 7;
      ur   = (nsend < 7);
    end else begin
      neff = (last_at >= 0) ? last_at + 1 : nsend;
      ur   = (last_at < 0);
    end
    build(sh, neff, bits, ur);
    fork
      drive(sh, nsend, last_at, bits);
      monitor(neff - 1 + (ur ? 1 : 0));
    join
    fidx++;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] b;
    logic [31:0] h;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pause_o == 1'b0, "R1", "pause after reset", pause_o, 0);
    chk(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
    chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);

    // R6 short frames, in_last asserted on an arbitrary bit and ignored
    for (int k = 0; k < 34; k++) begin
      int v;
      v = (k == 32) ? 0 : (k == 33) ? 127 : ((k * 37 + 5) & 127);
      b = 64'(v);
      run_frame(1'b1, 7, k % 7, b);
    end
    // R10 short frame cut off after 4 bits
    run_frame(1'b1, 4, -1, 64'h4);

    // R7 R8 standard frames ending on and inside byte boundaries
    for (int L = 16; L <= 24; L++) begin
      h = 32'h9E3779B9 * 32'(L);
      b = {h, ~h};
      run_frame(1'b0, L, L - 1, b);
    end
    run_frame(1'b0, 55, 54, 64'hC3A5_5A3C_0FF0_9669);
    run_frame(1'b0, 16, 15, 64'h0);
    run_frame(1'b0, 24, 23, {64{1'b1}});
    // R10 standard frame whose source stops after 40 bits
    run_frame(1'b0, 40, -1, 64'h1234_5678_9ABC_DEF0);

    finish_run();
  end

endmodule